// File: doc/BRIEF.md
# Flash Read Strobe Generator

This block drives the read strobe of an on-chip flash array once for every read or instruction fetch. The block runs on a fast reference clock. Each boundary of the slower system-clock cycle arrives as a one-tick enable, `sys_tick`. A request is serviced on a system-cycle boundary. The strobe then stays high for at most one or two system-clock cycles, as chosen by a read-time control bit. A programmable one-shot counter, counted in reference ticks, can end the pulse sooner. Whichever limit comes first ends the strobe, so at very slow system clocks the array drops back to low power long before the cycle is over.

Two small registers hold the settings. The control register carries the read-time bit at bit 4 and reads every other bit as zero. The one-shot register holds a 4-bit period in reference ticks. Its reset value of 8 ticks equals 80 ns at a 100 MHz reference. Both settings are captured when a strobe starts. Any change made during a pulse applies from the following pulse.

The control state machine has three states. IDLE waits for a pending request and a system-cycle boundary, and moves to ACTIVE. ACTIVE holds the strobe high. When a limit is reached it goes to IDLE, or to GAP if another request is waiting on the boundary where the pulse ends. GAP holds the strobe low for one tick and always moves to ACTIVE.

Top module: `flash_strobe_gen`

## Requirements
- R1: A request made while no other request is outstanding produces exactly one strobe pulse.
- R2: With the read-time bit (control bit 4) at 0, the strobe ends at the first system-cycle boundary after it starts. With the bit at 1, it ends at the second boundary. For a tick period of P reference cycles, the cycle limit is therefore P or 2P reference cycles.
- R3: The strobe is high for no more than L reference cycles, where L is the captured one-shot limit. The measured width is min(L, n*P), with n = 1 or 2.
- R4: After reset, the strobe is low, the low-power output is high, the control register reads 0x00 and the one-shot register reads 8.
- R5: A one-shot setting below the minimum (default 3) is treated as that minimum.
- R6: The low-power output is high exactly when the strobe is low.
- R7: The control register returns the read-time bit at bit 4 and zero in bits 7..5 and 3..0, whatever is written there. The one-shot register returns the value written to it.
- R8: The read-time bit and the one-shot period are sampled when a strobe starts. Writes made during a strobe do not change that strobe.
- R9: If a request is waiting at the boundary where a strobe ends, the strobe goes low for exactly one reference cycle and then rises again. This second pulse lasts min(L, n*P - 1) reference cycles.
- R10: A request that arrives when `sys_tick` is low is held. The strobe rises in the reference cycle after the next `sys_tick`, and rises at no other time except after GAP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sys_tick | input | 1 | One-tick marker of a system-clock cycle boundary |
| rd_req | input | 1 | Flash read or fetch request, one tick |
| ctl_we | input | 1 | Control register write enable |
| ctl_wdata | input | 8 | Control register write data (bit 4 = read-time bit) |
| os_we | input | 1 | One-shot register write enable |
| os_wdata | input | 4 | One-shot period in reference ticks |
| ctl_rdata | output | 8 | Control register read value |
| os_rdata | output | 4 | One-shot register read value |
| rd_strobe | output | 1 | Flash read strobe |
| flash_lowpwr | output | 1 | High while the array is in low power |

## Verification
The assertions check on every cycle the properties of each pulse. A pulse never runs past its captured one-shot limit. It ends on the first boundary in one-cycle mode and on the second in two-cycle mode. It rises only after a boundary or after GAP. The control read value is zero outside bit 4. The exact widths follow from min(L, n*P), and the benches's scenarios are needed to show them, along with the single low tick between back-to-back pulses, the longer wait after a one-shot cut-off, the clamping of small periods, and the rule that settings apply only to the next pulse. To do this, the bench sweeps every one-shot value and both modes across several tick periods.

// File: rtl/fsg_pkg.sv
package fsg_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ACTIVE = 2'd1,
        ST_GAP    = 2'd2
    } fsg_state_e;

    localparam int CTL_W  = 8;
    localparam int RT_POS = 4;
endpackage

// File: rtl/fsg_cfg_regs.sv
module fsg_cfg_regs
    import fsg_pkg::*;
#(
    parameter int OS_W     = 4,
    parameter int OS_RESET = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_we,
    input  logic [CTL_W-1:0]  ctl_wdata,
    input  logic              os_we,
    input  logic [OS_W-1:0]   os_wdata,
    output logic              rt_bit,
    output logic [OS_W-1:0]   os_val,
    output logic [CTL_W-1:0]  ctl_rdata
);
    logic unused_rsvd;
    assign unused_rsvd = ^{ctl_wdata[CTL_W-1:RT_POS+1], ctl_wdata[RT_POS-1:0]};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rt_bit <= 1'b0;
            os_val <= OS_W'(OS_RESET);
        end else begin
            if (ctl_we) rt_bit <= ctl_wdata[RT_POS];
            if (os_we)  os_val <= os_wdata;
        end
    end

    // only the read-time bit is backed by storage; all other bits read zero
    for (genvar i = 0; i < CTL_W; i++) begin : g_rd
        if (i == RT_POS) begin : g_rt
            assign ctl_rdata[i] = rt_bit;
        end else begin : g_zero
            assign ctl_rdata[i] = 1'b0;
        end
    end
endmodule

// File: rtl/fsg_req_latch.sv
module fsg_req_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    input  logic take,
    output logic pend,
    output logic want
);
    assign want = pend | req;

    always_ff @(posedge clk) begin
        if (!rst_n)    pend <= 1'b0;
        else if (take) pend <= 1'b0;
        else           pend <= want;
    end
endmodule

// File: rtl/fsg_pulse_timer.sv
module fsg_pulse_timer #(
    parameter int OS_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic            run,
    input  logic            sys_tick,
    input  logic            two_cyc,
    input  logic [OS_W-1:0] os_lim,
    output logic            expire
);
    logic [OS_W-1:0] tick_cnt;
    logic [1:0]      seen;
    logic [1:0]      cyc_lim;
    logic            os_hit;
    logic            cyc_hit;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tick_cnt <= '0;
            seen     <= '0;
        end else if (load) begin
            tick_cnt <= OS_W'(1);
            seen     <= '0;
        end else if (run) begin
            if (tick_cnt != '1) tick_cnt <= tick_cnt + 1'b1;
            if (sys_tick)       seen     <= seen + 2'd1;
        end
    end

    always_comb begin
        cyc_lim = two_cyc ? 2'd2 : 2'd1;
        os_hit  = (tick_cnt >= os_lim);
        cyc_hit = sys_tick && ((seen + 2'd1) >= cyc_lim);
        expire  = run && (os_hit || cyc_hit);
    end
endmodule

// File: rtl/flash_strobe_gen.sv
module flash_strobe_gen
    import fsg_pkg::*;
#(
    parameter int OS_W     = 4,
    parameter int OS_RESET = 8,
    parameter int OS_MIN   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sys_tick,
    input  logic              rd_req,
    input  logic              ctl_we,
    input  logic [CTL_W-1:0]  ctl_wdata,
    input  logic              os_we,
    input  logic [OS_W-1:0]   os_wdata,
    output logic [CTL_W-1:0]  ctl_rdata,
    output logic [OS_W-1:0]   os_rdata,
    output logic              rd_strobe,
    output logic              flash_lowpwr
);
    localparam logic [OS_W-1:0] MIN_LIM = OS_W'(OS_MIN);

    fsg_state_e      state_q, state_d;
    logic            rt_bit;
    logic [OS_W-1:0] os_val;
    logic            rt_q;
    logic [OS_W-1:0] os_lim_q;
    logic            pend;
    logic            want;
    logic            take;
    logic            expire;

    fsg_cfg_regs #(.OS_W(OS_W), .OS_RESET(OS_RESET)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl_we    (ctl_we),
        .ctl_wdata (ctl_wdata),
        .os_we     (os_we),
        .os_wdata  (os_wdata),
        .rt_bit    (rt_bit),
        .os_val    (os_val),
        .ctl_rdata (ctl_rdata)
    );
    assign os_rdata = os_val;

    fsg_req_latch u_req (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (rd_req),
        .take  (take),
        .pend  (pend),
        .want  (want)
    );

    fsg_pulse_timer #(.OS_W(OS_W)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (take),
        .run      (state_q == ST_ACTIVE),
        .sys_tick (sys_tick),
        .two_cyc  (rt_q),
        .os_lim   (os_lim_q),
        .expire   (expire)
    );

    // strobe start: from IDLE on a boundary, or always from GAP
    assign take = ((state_q == ST_IDLE) && sys_tick && want) || (state_q == ST_GAP);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // per-strobe snapshot of the settings, period clamped to the minimum
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rt_q     <= 1'b0;
            os_lim_q <= MIN_LIM;
        end else if (take) begin
            rt_q     <= rt_bit;
            os_lim_q <= (os_val < MIN_LIM) ? MIN_LIM : os_val;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (sys_tick && want) state_d = ST_ACTIVE;
            ST_ACTIVE: if (expire)           state_d = (sys_tick && want) ? ST_GAP : ST_IDLE;
            ST_GAP:                          state_d = ST_ACTIVE;
            default:                         state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        rd_strobe    = (state_q == ST_ACTIVE);
        flash_lowpwr = (state_q != ST_ACTIVE);
    end
endmodule

// File: rtl/fsg_chk.sv
module fsg_chk #(
    parameter int OS_W   = 4,
    parameter int OS_MIN = 3
) (
    input logic            clk,
    input logic            rst_n,
    input logic            sys_tick,
    input logic            rd_req,
    input logic            rd_strobe,
    input logic [7:0]      ctl_rdata,
    input logic            rt_q,
    input logic [OS_W-1:0] os_lim_q,
    input logic            in_gap,
    input logic            pend
);
    logic [OS_W-1:0] hi_cnt;
    logic [1:0]      ticks_in;

    always_ff @(posedge clk) begin
        if (!rst_n || !rd_strobe) begin
            hi_cnt   <= '0;
            ticks_in <= '0;
        end else begin
            hi_cnt <= hi_cnt + 1'b1;
            if (sys_tick) ticks_in <= ticks_in + 2'd1;
        end
    end

    // R2
    one_cycle_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_strobe && sys_tick && !rt_q |=> !rd_strobe);

    // R2
    two_cycle_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_strobe && sys_tick && (ticks_in == 2'd1) |=> !rd_strobe);

    // R3
    oneshot_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_strobe |-> (hi_cnt < os_lim_q));

    // R5
    min_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_strobe |-> (os_lim_q >= OS_W'(OS_MIN)));

    // R7
    rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_rdata & 8'hEF) == 8'h00);

    // R10
    rise_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_strobe) |-> ($past(sys_tick) || $past(in_gap)));

    // R10
    req_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req && !rd_strobe && !in_gap && !sys_tick |=> pend);
endmodule

bind flash_strobe_gen fsg_chk #(.OS_W(OS_W), .OS_MIN(OS_MIN)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sys_tick  (sys_tick),
    .rd_req    (rd_req),
    .rd_strobe (rd_strobe),
    .ctl_rdata (ctl_rdata),
    .rt_q      (rt_q),
    .os_lim_q  (os_lim_q),
    .in_gap    (state_q == fsg_pkg::ST_GAP),
    .pend      (pend)
);

// File: tb/flash_strobe_gen_tb.sv
module flash_strobe_gen_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sys_tick = 1'b0;
    logic       rd_req = 1'b0;
    logic       ctl_we = 1'b0;
    logic [7:0] ctl_wdata = '0;
    logic       os_we = 1'b0;
    logic [3:0] os_wdata = '0;
    logic [7:0] ctl_rdata;
    logic [3:0] os_rdata;
    logic       rd_strobe;
    logic       flash_lowpwr;

    int vectors = 0;
    int fails = 0;
    int P = 4;
    int phase = 0;

    int hi_run = 0, lo_run = 0;
    int last_width = 0, prev_width = 0, last_gap = 0;
    int pulse_cnt = 0, rise_cnt = 0;
    int misaligned = 0, lp_bad = 0;
    logic prev_strobe = 1'b0;

    always #5 clk = ~clk;

    flash_strobe_gen u_dut (
        .clk(clk), .rst_n(rst_n), .sys_tick(sys_tick), .rd_req(rd_req),
        .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .os_we(os_we), .os_wdata(os_wdata),
        .ctl_rdata(ctl_rdata), .os_rdata(os_rdata), .rd_strobe(rd_strobe),
        .flash_lowpwr(flash_lowpwr)
    );

    // boundary generator, one tick every P reference cycles
    always @(negedge clk) begin
        phase = (phase + 1 >= P) ? 0 : phase + 1;
        sys_tick = (phase == 0);
    end

    // pulse monitor, sampled just after each edge
    always @(posedge clk) begin
        #1;
        if (rst_n) begin
            if (flash_lowpwr == rd_strobe) lp_bad++;
            if (rd_strobe) begin
                if (!prev_strobe) begin
                    last_gap = lo_run;
                    rise_cnt++;
                    if (!(sys_tick || lo_run == 1)) misaligned++;
                    hi_run = 0;
                end
                hi_run++;
            end else begin
                if (prev_strobe) begin
                    prev_width = last_width;
                    last_width = hi_run;
                    pulse_cnt++;
                    lo_run = 0;
                end
                lo_run++;
            end
            prev_strobe = rd_strobe;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr_ctl(input logic [7:0] d);
        @(negedge clk); ctl_we = 1'b1; ctl_wdata = d;
        @(negedge clk); ctl_we = 1'b0;
    endtask

    task automatic wr_os(input logic [3:0] d);
        @(negedge clk); os_we = 1'b1; os_wdata = d;
        @(negedge clk); os_we = 1'b0;
    endtask

    task automatic req_once();
        @(negedge clk); rd_req = 1'b1;
        @(negedge clk); rd_req = 1'b0;
    endtask

    task automatic wait_pulses(input int target);
        while (pulse_cnt < target) @(negedge clk);
    endtask

    task automatic wait_rises(input int target);
        while (rise_cnt < target) @(negedge clk);
    endtask

    initial begin
        #1_500_000;
        fails++;
        vectors++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        int base, lim, exp_w;
        int plist[6] = '{1, 2, 3, 5, 8, 16};
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R4 reset state
        check(rd_strobe == 1'b0, "R4 strobe", rd_strobe, 0);
        check(flash_lowpwr == 1'b1, "R4 lowpwr", flash_lowpwr, 1);
        check(ctl_rdata == 8'h00, "R4 ctl", ctl_rdata, 0);
        check(os_rdata == 4'd8, "R4 oneshot", os_rdata, 8);

        // R7 register layout
        wr_ctl(8'hFF);
        check(ctl_rdata == 8'h10, "R7 all-ones write", ctl_rdata, 16);
        wr_ctl(8'hEF);
        check(ctl_rdata == 8'h00, "R7 reserved only", ctl_rdata, 0);
        wr_os(4'd9);
        check(os_rdata == 4'd9, "R7 oneshot readback", os_rdata, 9);

        // R1 R2 R3 R5 sweep over tick period, mode and every one-shot value
        foreach (plist[pi]) begin
            P = plist[pi];
            for (int rt = 0; rt < 2; rt++) begin
                wr_ctl(8'(rt << 4));
                for (int os = 0; os < 16; os++) begin
                    wr_os(4'(os));
                    base = pulse_cnt;
                    req_once();
                    wait_pulses(base + 1);
                    repeat (2 * P + 4) @(negedge clk);
                    check(pulse_cnt == base + 1, "R1 single pulse", pulse_cnt - base, 1);
                    lim = (os < 3) ? 3 : os;
                    exp_w = (lim < (rt + 1) * P) ? lim : (rt + 1) * P;
                    if (os < 3)
                        check(last_width == exp_w, "R5 clamped width", last_width, exp_w);
                    else if (lim < (rt + 1) * P)
                        check(last_width == exp_w, "R3 oneshot width", last_width, exp_w);
                    else
                        check(last_width == exp_w, "R2 cycle width", last_width, exp_w);
                end
            end
        end

        // R9 back-to-back on the ending boundary
        P = 4;
        wr_ctl(8'h00);
        wr_os(4'd15);
        base = pulse_cnt;
        req_once();
        wait_rises(rise_cnt + 1);
        req_once();
        wait_pulses(base + 2);
        check(prev_width == 4, "R9 first width", prev_width, 4);
        check(last_width == 3, "R9 second width", last_width, 3);
        check(last_gap == 1, "R9 one-tick gap", last_gap, 1);

        // R10 one-shot cut-off, next request waits for the boundary
        P = 16;
        wr_os(4'd5);
        repeat (20) @(negedge clk);
        base = pulse_cnt;
        req_once();
        wait_rises(rise_cnt + 1);
        req_once();
        wait_pulses(base + 2);
        check(prev_width == 5 && last_width == 5, "R10 widths", last_width, 5);
        check(last_gap == 11, "R10 held until boundary", last_gap, 11);

        // R8 settings captured at strobe start
        P = 8;
        wr_ctl(8'h10);
        wr_os(4'd15);
        repeat (20) @(negedge clk);
        base = pulse_cnt;
        req_once();
        wait_rises(rise_cnt + 1);
        wr_os(4'd4);
        wr_ctl(8'h00);
        wait_pulses(base + 1);
        check(last_width == 15, "R8 in-flight unchanged", last_width, 15);
        repeat (20) @(negedge clk);
        req_once();
        wait_pulses(base + 2);
        check(last_width == 4, "R8 next pulse updated", last_width, 4);

        check(misaligned == 0, "R10 rise alignment", misaligned, 0);
        check(lp_bad == 0, "R6 lowpwr mirror", lp_bad, 0);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule